// File: doc/BRIEF.md
# Power Source Hard Reset Sequencer

This block runs the supply side of a power source's response to a received Hard Reset on a USB Power Delivery port. It normally keeps VBUS, VCONN and the pull-up on the VCONN pin switched on. When a hard-reset pulse arrives, it keeps VBUS at its present level for a fixed hold time. It then switches VBUS, VCONN and the VCONN-pin pull-up off together. After a recovery wait it switches all three back on. Once VBUS is reported at safe 5 V, it asks the message layer to send Source Capabilities.

All timing is counted in pulses of a one-clock-wide millisecond tick supplied from outside. The recovery wait starts when the optional "VBUS at safe 0 V" indication is reported. If that indication never comes, the block waits for the worst-case discharge allowance plus the recovery time. If safe 5 V is not seen in time after VBUS is re-enabled, the block raises a fault and returns to the idle state with the supplies on. A new hard-reset pulse at any point restarts the sequence from the hold phase.

Top module: `src_hr_seq`

## Requirements
- R1: After reset, vbus_en, vconn_en and vconn_rp_en are 1, and src_caps_req, seq_done and seq_fault are 0.
- R2: vbus_en falls in the cycle after the HOLD_MS-th (default 30) tick counted from the hard_reset_rx pulse. Ticks are counted on clock edges where ms_tick is 1. A vbus_safe0 pulse during the hold phase is ignored.
- R3: vconn_en and vconn_rp_en always equal vbus_en. They turn off and back on in the same cycle as VBUS.
- R4: A vbus_safe0 pulse while VBUS is off starts the recovery wait. vbus_en rises after RECOVER_MS (default 800) further ticks.
- R5: Without any vbus_safe0 pulse, vbus_en rises after SAFE0_MAX_MS + RECOVER_MS (default 1450) ticks counted from VBUS turning off.
- R6: A vbus_safe5 pulse while VBUS is back on gives a one-cycle src_caps_req at the next edge. seq_done pulses for one cycle in the following cycle. vbus_safe5 at any other time is ignored.
- R7: If vbus_safe5 is not seen within TURNON_MAX_MS (default 275) ticks of VBUS re-enable, seq_fault goes to 1 and the block returns to idle with VBUS on and no src_caps_req. seq_fault clears on the next hard_reset_rx.
- R8: A hard_reset_rx pulse during the sequence restarts it from the hold phase. VBUS is on in the next cycle, and the hold count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| hard_reset_rx | input | 1 | Hard Reset received pulse |
| vbus_safe0 | input | 1 | VBUS reached safe 0 V (optional) |
| vbus_safe5 | input | 1 | VBUS reached safe 5 V |
| vbus_en | output | 1 | VBUS supply enable |
| vconn_en | output | 1 | VCONN supply enable |
| vconn_rp_en | output | 1 | Pull-up on the VCONN pin enable |
| src_caps_req | output | 1 | Request to send Source Capabilities (pulse) |
| seq_done | output | 1 | Sequence completed (pulse) |
| seq_fault | output | 1 | Safe 5 V not reached in time |

## Verification
The hardest situations to reach are the ones that depend on what the block ignores. These are a safe-0 V report that comes too early (during the hold phase), a safe-5 V report while VBUS is still off, and a hard reset that lands in the middle of the discharge wait. The stimulus keeps its own tick count from each hard-reset pulse. It places these stray pulses at chosen tick counts inside the phase where they must have no effect. It then checks that every later VBUS edge still falls on the exact tick the requirements predict. Any wrongly accepted pulse shows up as an early or unexpected event in the scoreboard.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_OFF   = 3'd2,
        ST_RECOV = 3'd3,
        ST_ON    = 3'd4,
        ST_CAPS  = 3'd5
    } hrs_state_e;

    typedef struct packed {
        logic vbus;
        logic vconn;
        logic rp;
    } supply_t;

    // supplies are only dropped while discharging or recovering
    function automatic supply_t supply_for(hrs_state_e st);
        supply_t s;
        logic    on;
        on      = !(st == ST_OFF || st == ST_RECOV);
        s.vbus  = on;
        s.vconn = on;
        s.rp    = on;
        return s;
    endfunction

    // true on the tick that completes a window of lim ticks
    function automatic logic window_end(input int unsigned cnt, input logic tick,
                                        input int unsigned lim);
        return tick && (cnt == lim - 1);
    endfunction

endpackage

// File: rtl/hrs_timer.sv
module hrs_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hrs_fsm.sv
module hrs_fsm
    import hrs_pkg::*;
#(
    parameter int CNT_W         = 11,
    parameter int HOLD_MS       = 30,
    parameter int SAFE0_MAX_MS  = 650,
    parameter int RECOVER_MS    = 800,
    parameter int TURNON_MAX_MS = 275
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             hr_pulse,
    input  logic             safe0,
    input  logic             safe5,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output hrs_state_e       state,
    output logic             done,
    output logic             fault
);
    localparam int unsigned FALLBACK_MS = SAFE0_MAX_MS + RECOVER_MS;

    hrs_state_e  state_n;
    logic        timeout_on;
    int unsigned cnt_i;

    assign cnt_i = int'(cnt);

    always_comb begin
        state_n    = state;
        timeout_on = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_HOLD:  if (window_end(cnt_i, tick, HOLD_MS)) state_n = ST_OFF;
            ST_OFF: begin
                if (safe0)
                    state_n = ST_RECOV;
                else if (window_end(cnt_i, tick, FALLBACK_MS))
                    state_n = ST_ON;
            end
            ST_RECOV: if (window_end(cnt_i, tick, RECOVER_MS)) state_n = ST_ON;
            ST_ON: begin
                if (safe5)
                    state_n = ST_CAPS;
                else if (window_end(cnt_i, tick, TURNON_MAX_MS)) begin
                    state_n    = ST_IDLE;
                    timeout_on = 1'b1;
                end
            end
            ST_CAPS:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
        if (hr_pulse) begin
            state_n    = ST_HOLD;
            timeout_on = 1'b0;
        end
    end

    assign cnt_clr = hr_pulse || (state_n != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            fault <= 1'b0;
        end else begin
            state <= state_n;
            done  <= (state == ST_CAPS) && !hr_pulse;
            if (hr_pulse)
                fault <= 1'b0;
            else if (timeout_on)
                fault <= 1'b1;
        end
    end
endmodule

// File: rtl/hrs_outdec.sv
module hrs_outdec
    import hrs_pkg::*;
(
    input  hrs_state_e state,
    output supply_t    sup,
    output logic       caps_req
);
    assign sup      = supply_for(state);
    assign caps_req = (state == ST_CAPS);
endmodule

// File: rtl/src_hr_seq.sv
module src_hr_seq
    import hrs_pkg::*;
#(
    parameter int HOLD_MS       = 30,
    parameter int SAFE0_MAX_MS  = 650,
    parameter int RECOVER_MS    = 800,
    parameter int TURNON_MAX_MS = 275
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic hard_reset_rx,
    input  logic vbus_safe0,
    input  logic vbus_safe5,
    output logic vbus_en,
    output logic vconn_en,
    output logic vconn_rp_en,
    output logic src_caps_req,
    output logic seq_done,
    output logic seq_fault
);
    localparam int MAX_WIN = SAFE0_MAX_MS + RECOVER_MS;
    localparam int CNT_W   = $clog2(MAX_WIN + 1);

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    hrs_state_e       state;
    supply_t          sup;

    hrs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .tick (ms_tick),
        .cnt  (cnt)
    );

    hrs_fsm #(
        .CNT_W        (CNT_W),
        .HOLD_MS      (HOLD_MS),
        .SAFE0_MAX_MS (SAFE0_MAX_MS),
        .RECOVER_MS   (RECOVER_MS),
        .TURNON_MAX_MS(TURNON_MAX_MS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (ms_tick),
        .hr_pulse (hard_reset_rx),
        .safe0    (vbus_safe0),
        .safe5    (vbus_safe5),
        .cnt      (cnt),
        .cnt_clr  (cnt_clr),
        .state    (state),
        .done     (seq_done),
        .fault    (seq_fault)
    );

    hrs_outdec u_outdec (
        .state    (state),
        .sup      (sup),
        .caps_req (src_caps_req)
    );

    assign vbus_en     = sup.vbus;
    assign vconn_en    = sup.vconn;
    assign vconn_rp_en = sup.rp;
endmodule

// File: rtl/src_hr_seq_chk.sv
module src_hr_seq_chk (
    input logic clk,
    input logic rst,
    input logic ms_tick,
    input logic hard_reset_rx,
    input logic vbus_safe5,
    input logic vbus_en,
    input logic vconn_en,
    input logic vconn_rp_en,
    input logic src_caps_req,
    input logic seq_done,
    input logic seq_fault
);
    // R2
    vbus_drop_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vbus_en) |-> $past(ms_tick));

    // R3
    supplies_together_chk: assert property (@(posedge clk) disable iff (rst)
        (vconn_en == vbus_en) && (vconn_rp_en == vbus_en));

    // R6
    caps_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        src_caps_req && !hard_reset_rx |=> seq_done && !src_caps_req);

    // R6
    caps_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(src_caps_req) |-> $past(vbus_safe5) && $past(vbus_en));

    // R7
    fault_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_fault) |-> vbus_en && !src_caps_req);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        hard_reset_rx |=> vbus_en && !src_caps_req && !seq_fault);
endmodule

bind src_hr_seq src_hr_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ms_tick      (ms_tick),
    .hard_reset_rx(hard_reset_rx),
    .vbus_safe5   (vbus_safe5),
    .vbus_en      (vbus_en),
    .vconn_en     (vconn_en),
    .vconn_rp_en  (vconn_rp_en),
    .src_caps_req (src_caps_req),
    .seq_done     (seq_done),
    .seq_fault    (seq_fault)
);

// File: tb/src_hr_seq_bench.sv
`timescale 1ns/1ps
module src_hr_seq_bench;
    localparam int HOLD = 30, S0MAX = 650, RECOV = 800, TON = 275;
    localparam int K_OFF = 0, K_ON = 1, K_CAPS = 2, K_FAULT = 3;

    typedef struct {
        int kind;
        int ticks;   // -1: any tick count
        string req;
    } ev_t;

    logic clk = 1'b0, rst = 1'b1;
    logic ms_tick = 1'b0, hard_reset_rx = 1'b0, vbus_safe0 = 1'b0, vbus_safe5 = 1'b0;
    logic vbus_en, vconn_en, vconn_rp_en, src_caps_req, seq_done, seq_fault;

    int checks = 0, failures = 0;
    int tcount = 0;
    int div = 0;
    ev_t sb[$];
    logic started = 1'b0;
    logic prev_vbus = 1'b1, prev_fault = 1'b0, want_done = 1'b0;
    string kname [4] = '{"VBUS_OFF", "VBUS_ON", "CAPS", "FAULT"};

    always #2.5 clk = ~clk;

    src_hr_seq u_src_hr_seq (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .hard_reset_rx(hard_reset_rx),
        .vbus_safe0(vbus_safe0), .vbus_safe5(vbus_safe5), .vbus_en(vbus_en),
        .vconn_en(vconn_en), .vconn_rp_en(vconn_rp_en), .src_caps_req(src_caps_req),
        .seq_done(seq_done), .seq_fault(seq_fault)
    );

    // tick source: one pulse every 4 cycles
    always @(negedge clk) begin
        div     <= (div == 3) ? 0 : div + 1;
        ms_tick <= (div == 3) && !rst;
    end

    // tick count since last hard reset pulse
    always @(posedge clk) begin
        if (hard_reset_rx) tcount <= 0;
        else if (ms_tick) tcount <= tcount + 1;
    end

    task automatic check(input string req, input logic ok, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int ticks, input string req);
        ev_t e;
        e.kind = kind; e.ticks = ticks; e.req = req;
        sb.push_back(e);
    endtask

    task automatic seen(input int kind);
        ev_t e;
        if (sb.size() == 0) begin
            check("R8", 1'b0, {"unexpected ", kname[kind]}, tcount, -1);
            return;
        end
        e = sb.pop_front();
        check(e.req, e.kind == kind, "event kind", kind, e.kind);
        if (e.ticks >= 0)
            check(e.req, tcount == e.ticks, {kname[kind], " tick"}, tcount, e.ticks);
    endtask

    // monitor
    always @(negedge clk) begin
        if (started) begin
            if (want_done) begin
                check("R6", seq_done === 1'b1, "done after caps", int'(seq_done), 1);
                want_done = 1'b0;
            end
            if (vbus_en !== prev_vbus) begin
                check("R3", vconn_en === vbus_en && vconn_rp_en === vbus_en,
                      "vconn/rp follow vbus", int'({vconn_en, vconn_rp_en}),
                      vbus_en ? 3 : 0);
                seen(vbus_en ? K_ON : K_OFF);
            end
            if (src_caps_req === 1'b1) begin
                seen(K_CAPS);
                want_done = 1'b1;
            end
            if (seq_fault === 1'b1 && prev_fault === 1'b0) seen(K_FAULT);
        end
        prev_vbus  = vbus_en;
        prev_fault = seq_fault;
    end

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic wait_tcount(input int n);
        while (tcount < n) @(negedge clk);
    endtask

    task automatic wait_vbus_on();
        while (vbus_en !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("R1", 1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", vbus_en === 1'b1, "vbus_en", int'(vbus_en), 1);
        check("R1", vconn_en === 1'b1 && vconn_rp_en === 1'b1, "vconn/rp",
              int'({vconn_en, vconn_rp_en}), 3);
        check("R1", src_caps_req === 1'b0 && seq_done === 1'b0 && seq_fault === 1'b0,
              "caps/done/fault", int'({src_caps_req, seq_done, seq_fault}), 0);
        started = 1'b1;

        // safe0 reported; early safe0 in hold ignored (R2, R4, R6)
        expect_ev(K_OFF, HOLD, "R2");
        expect_ev(K_ON, 100 + RECOV, "R4");
        expect_ev(K_CAPS, -1, "R6");
        pulse(hard_reset_rx);
        wait_tcount(10);
        pulse(vbus_safe0);
        wait_tcount(100);
        pulse(vbus_safe0);
        wait_vbus_on();
        pulse(vbus_safe5);
        drain();

        // no safe0: fallback window; stray safe5 while off ignored (R5, R6)
        expect_ev(K_OFF, HOLD, "R2");
        expect_ev(K_ON, HOLD + S0MAX + RECOV, "R5");
        expect_ev(K_CAPS, -1, "R6");
        pulse(hard_reset_rx);
        wait_tcount(200);
        pulse(vbus_safe5);
        wait_vbus_on();
        pulse(vbus_safe5);
        drain();

        // safe5 never comes: fault (R7)
        expect_ev(K_OFF, HOLD, "R2");
        expect_ev(K_ON, 50 + RECOV, "R4");
        expect_ev(K_FAULT, 50 + RECOV + TON, "R7");
        pulse(hard_reset_rx);
        wait_tcount(50);
        pulse(vbus_safe0);
        drain();
        check("R7", seq_fault === 1'b1, "fault held", int'(seq_fault), 1);
        check("R7", vbus_en === 1'b1 && src_caps_req === 1'b0, "idle after fault",
              int'({vbus_en, src_caps_req}), 2);

        // hard reset clears fault, then restart mid-discharge (R7, R8)
        expect_ev(K_OFF, HOLD, "R2");
        pulse(hard_reset_rx);
        check("R7", seq_fault === 1'b0, "fault cleared", int'(seq_fault), 0);
        wait_tcount(400);
        expect_ev(K_ON, 0, "R8");
        expect_ev(K_OFF, HOLD, "R8");
        expect_ev(K_ON, HOLD + S0MAX + RECOV, "R5");
        expect_ev(K_CAPS, -1, "R6");
        pulse(hard_reset_rx);
        wait_vbus_on();
        wait_tcount(HOLD + 5);
        wait_vbus_on();
        pulse(vbus_safe5);
        drain();

        check("R6", sb.size() == 0, "scoreboard empty", sb.size(), 0);
        check("R6", seq_done === 1'b0 && src_caps_req === 1'b0, "pulses ended",
              int'({seq_done, src_caps_req}), 0);
        finish_run();
    end
endmodule